// File: doc/BRIEF.md
# Manchester Line Encoder with Frame-End Idle

This block turns a stream of bytes into a Manchester-coded differential pair for a 10 Mb/s twisted-pair link. Each byte arrives over a valid/ready handshake and goes into a shift register. The bits leave least significant bit first. Each bit time lasts eight encoder clock cycles, split into two half-bits of four cycles each. A 1 bit is sent as a low-to-high transition and a 0 bit as a high-to-low transition. When no bit is being sent, both lines rest low.

A link-pulse generator elsewhere on the chip shares the pair. It raises a busy flag while its pulse is on the wire. The encoder checks that flag at every bit boundary and holds the next bit back until the flag drops. A bit that has already started always runs to its end.

To close a frame, the user raises an end-of-frame request with a delay value. The encoder first counts that delay down, so that any bits still queued can leave. It then drives the end-of-frame idle pulse: the positive line high and the negative line low for three bit times. After that it holds both lines low for 64 bit times. At the end of that gap it raises a one-cycle done pulse. No new bytes are accepted while the frame-end sequence is running.

Top module: `manch_tx_top`

## Requirements
- R1: A 1 bit drives tx_n high and tx_p low for 4 cycles, then tx_p high and tx_n low for 4 cycles.
- R2: A 0 bit drives tx_p high and tx_n low for 4 cycles, then tx_n high and tx_p low for 4 cycles.
- R3: A new bit does not start in a cycle where lp_busy is sampled high. A bit already in progress completes in full, and both lines stay low while a pending bit is held back.
- R4: Bits leave least significant bit first. A byte loaded before the last bit of the previous byte ends follows that bit with no gap.
- R5: tx_p and tx_n are both low whenever no bit and no frame-end pulse is being driven.
- R6: An end-of-frame request is taken when no frame-end sequence is active. For a delay value D, tx_p rises D+2 cycles after the accepting clock edge and then stays high, with tx_n low, for exactly 24 cycles.
- R7: After the idle pulse, both lines stay low for 512 cycles. done is high for exactly one cycle, and that cycle is the last of the 512.
- R8: in_ready is high only when the shift register is empty and no frame-end sequence is active. A byte is taken on a clock edge where in_valid and in_ready are both high, and in_ready is low in the following cycle.
- R9: After reset, tx_p, tx_n and done are low and in_ready is high.
- R10: tx_p and tx_n are never high in the same cycle.
- R11: An end-of-frame request that arrives while a frame-end sequence is already active has no effect on the lines or on done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock, 8 cycles per bit time |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | in_data holds a byte to send |
| in_ready | output | 1 | Encoder can take a byte this cycle |
| lp_busy | input | 1 | Link pulse is on the wire; hold the next bit back |
| eof_req | input | 1 | Request to close the frame |
| eof_delay | input | 16 | Drain count in cycles, sampled with eof_req |
| tx_p | output | 1 | Positive line of the pair |
| tx_n | output | 1 | Negative line of the pair |
| done | output | 1 | One-cycle pulse at the end of the idle gap |

## Verification
The assertions check four things on every cycle. The two lines are never high together. in_ready falls after each accepted byte and stays low while a frame-end sequence is active. done lasts one cycle and only occurs with both lines low. A bit that starts from idle always follows a cycle in which lp_busy was low.

Some behaviour only the bench scenarios can show:
- the exact width and position of the 24-cycle idle pulse after a given drain delay;
- the 512-cycle gap;
- least-significant-bit-first ordering and gap-free back-to-back bytes;
- that a request repeated during the sequence changes nothing.

The bench shows these by decoding the lines, measuring run lengths, and comparing against a cycle-stepped model under random link-pulse and traffic patterns.

// File: rtl/manch_pkg.sv
package manch_pkg;

  // Frame-end sequencer phases; order is the sequence order.
  typedef enum logic [1:0] {
    EOF_IDLE  = 2'd0,
    EOF_DRAIN = 2'd1,
    EOF_PULSE = 2'd2,
    EOF_GAP   = 2'd3
  } eof_state_e;

endpackage

// File: rtl/manch_bit_ser.sv
// Shift register plus bit-time engine. Emits unregistered line levels
// that the top module registers.
module manch_bit_ser #(
  parameter int DATA_W   = 8,
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_en,
  input  logic              lp_busy,
  output logic              empty,
  output logic              line_p,
  output logic              line_n
);

  localparam int BIT_CYC = 2 * HALF_CYC;
  localparam int PH_W    = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int BC_W    = $clog2(DATA_W + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CYC - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF_CYC);

  logic [DATA_W-1:0] sh_q;
  logic [BC_W-1:0]   left_q;
  logic [PH_W-1:0]   ph_q;
  logic              cur_q;
  logic              snd_q;

  logic bit_end;
  logic can_start;

  assign bit_end   = !snd_q || (ph_q == PH_LAST);
  assign can_start = (left_q != '0) && !lp_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      left_q <= '0;
      ph_q   <= '0;
      cur_q  <= 1'b0;
      snd_q  <= 1'b0;
    end else begin
      if (!bit_end) begin
        ph_q <= ph_q + 1'b1;
      end else if (can_start) begin
        cur_q  <= sh_q[0];
        sh_q   <= sh_q >> 1;
        left_q <= left_q - 1'b1;
        snd_q  <= 1'b1;
        ph_q   <= '0;
      end else begin
        snd_q <= 1'b0;
        ph_q  <= '0;
      end
      // A load is only permitted while left_q is zero, so it never
      // collides with a bit start in the same cycle.
      if (ld_en) begin
        sh_q   <= ld_data;
        left_q <= BC_W'(DATA_W);
      end
    end
  end

  logic first_half;
  assign first_half = (ph_q < PH_HALF);

  assign empty  = (left_q == '0);
  assign line_p = snd_q && (first_half ? !cur_q : cur_q);
  assign line_n = snd_q && (first_half ? cur_q : !cur_q);

endmodule

// File: rtl/manch_eof_seq.sv
// Drain countdown, idle pulse and quiet gap that close a frame.
module manch_eof_seq
  import manch_pkg::*;
#(
  parameter int DLY_W   = 16,
  parameter int IDL_CYC = 24,
  parameter int GAP_CYC = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [DLY_W-1:0] dly,
  output logic             busy,
  output logic             force_lines,
  output logic             drive_hi,
  output logic             fin
);

  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam int IDL_W = $clog2(IDL_CYC + 1);
  localparam int MX_W  = (GAP_W > IDL_W) ? GAP_W : IDL_W;
  localparam int CNT_W = (DLY_W > MX_W) ? DLY_W : MX_W;

  eof_state_e      st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= EOF_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        EOF_IDLE: begin
          if (req) begin
            st_q  <= EOF_DRAIN;
            cnt_q <= CNT_W'(dly);
          end
        end
        EOF_DRAIN: begin
          if (cnt_zero) begin
            st_q  <= EOF_PULSE;
            cnt_q <= CNT_W'(IDL_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        EOF_PULSE: begin
          if (cnt_zero) begin
            st_q  <= EOF_GAP;
            cnt_q <= CNT_W'(GAP_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        EOF_GAP: begin
          if (cnt_zero) begin
            st_q <= EOF_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= EOF_IDLE;
      endcase
    end
  end

  assign busy        = (st_q != EOF_IDLE);
  assign force_lines = (st_q == EOF_PULSE) || (st_q == EOF_GAP);
  assign drive_hi    = (st_q == EOF_PULSE);
  assign fin         = (st_q == EOF_GAP) && cnt_zero;

endmodule

// File: rtl/manch_tx_top.sv
// Manchester line encoder: byte intake, bit serialiser, frame-end
// sequencer and registered line drivers.
module manch_tx_top #(
  parameter int DATA_W    = 8,
  parameter int HALF_CYC  = 4,
  parameter int DLY_W     = 16,
  parameter int IDL_BITS  = 3,
  parameter int GAP_BITS  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              lp_busy,
  input  logic              eof_req,
  input  logic [DLY_W-1:0]  eof_delay,
  output logic              tx_p,
  output logic              tx_n,
  output logic              done
);

  localparam int BIT_CYC = 2 * HALF_CYC;
  localparam int IDL_CYC = IDL_BITS * BIT_CYC;
  localparam int GAP_CYC = GAP_BITS * BIT_CYC;

  logic ser_empty, ser_p, ser_n;
  logic eof_busy, eof_force, eof_hi, eof_fin;
  logic ld_en;

  assign in_ready = ser_empty && !eof_busy;
  assign ld_en    = in_valid && in_ready;

  manch_bit_ser #(
    .DATA_W  (DATA_W),
    .HALF_CYC(HALF_CYC)
  ) u_ser (
    .clk    (clk),
    .rst    (rst),
    .ld_data(in_data),
    .ld_en  (ld_en),
    .lp_busy(lp_busy),
    .empty  (ser_empty),
    .line_p (ser_p),
    .line_n (ser_n)
  );

  manch_eof_seq #(
    .DLY_W  (DLY_W),
    .IDL_CYC(IDL_CYC),
    .GAP_CYC(GAP_CYC)
  ) u_eof (
    .clk        (clk),
    .rst        (rst),
    .req        (eof_req && !eof_busy),
    .dly        (eof_delay),
    .busy       (eof_busy),
    .force_lines(eof_force),
    .drive_hi   (eof_hi),
    .fin        (eof_fin)
  );

  logic p_d, n_d;
  assign p_d = eof_force ? eof_hi : ser_p;
  assign n_d = eof_force ? 1'b0   : ser_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_p <= 1'b0;
      tx_n <= 1'b0;
      done <= 1'b0;
    end else begin
      tx_p <= p_d;
      tx_n <= n_d;
      done <= eof_fin;
    end
  end

endmodule

// File: rtl/manch_tx_chk.sv
module manch_tx_chk (
  input logic clk,
  input logic rst,
  input logic tx_p,
  input logic tx_n,
  input logic done,
  input logic in_valid,
  input logic in_ready,
  input logic lp_busy,
  input logic eof_busy
);

  // R10
  no_short_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_p && tx_n));

  // R8
  accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  eof_block_chk: assert property (@(posedge clk) disable iff (rst)
    eof_busy |-> !in_ready);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!tx_p && !tx_n));

  // R3
  busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_n) && $past(!tx_p)) |-> $past(!lp_busy, 2));

endmodule

bind manch_tx_top manch_tx_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_p    (tx_p),
  .tx_n    (tx_n),
  .done    (done),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .lp_busy (lp_busy),
  .eof_busy(eof_busy)
);

// File: tb/sim_manch_tx_top.sv
`timescale 1ns/1ps
module sim_manch_tx_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        lp_busy = 1'b0;
  logic        eof_req = 1'b0;
  logic [15:0] eof_delay = '0;
  logic        tx_p, tx_n, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  manch_tx_top u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .lp_busy(lp_busy), .eof_req(eof_req),
    .eof_delay(eof_delay), .tx_p(tx_p), .tx_n(tx_n), .done(done)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Behavioural reference: queue of pending bits, bit phase, frame-end phase.
  bit q[$];
  int m_ph = 0, m_st = 0, m_cnt = 0;
  bit m_snd = 0, m_cur = 0;
  bit m_p = 0, m_n = 0, m_done = 0, m_ready = 1;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_ph = 0; m_st = 0; m_cnt = 0; m_snd = 0; m_cur = 0;
      m_p = 0; m_n = 0; m_done = 0; m_ready = 1;
    end else begin
      bit ep, en, rdy;
      ep = 0; en = 0;
      if (m_snd) begin
        ep = (m_ph < 4) ? !m_cur : m_cur;
        en = !ep;
      end
      if (m_st == 2) begin ep = 1; en = 0; end
      if (m_st == 3) begin ep = 0; en = 0; end
      m_done = (m_st == 3 && m_cnt == 0);
      m_p = ep; m_n = en;
      rdy = (q.size() == 0) && (m_st == 0);
      if (m_snd && m_ph < 7) m_ph++;
      else if (q.size() > 0 && !lp_busy) begin
        m_cur = q.pop_front(); m_snd = 1; m_ph = 0;
      end else begin
        m_snd = 0; m_ph = 0;
      end
      if (in_valid && rdy)
        for (int i = 0; i < 8; i++) q.push_back(in_data[i]);
      case (m_st)
        0: if (eof_req) begin m_st = 1; m_cnt = eof_delay; end
        1: if (m_cnt == 0) begin m_st = 2; m_cnt = 23; end else m_cnt--;
        2: if (m_cnt == 0) begin m_st = 3; m_cnt = 511; end else m_cnt--;
        default: if (m_cnt == 0) m_st = 0; else m_cnt--;
      endcase
      m_ready = (q.size() == 0) && (m_st == 0);
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R1/R2/R5/R6", "tx_p vs model", tx_p, m_p);
      chk("R1/R2/R5/R6", "tx_n vs model", tx_n, m_n);
      chk("R7/R11", "done vs model", done, m_done);
      chk("R8", "in_ready vs model", in_ready, m_ready);
      chk("R10", "lines exclusive", tx_p & tx_n, 0);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: got %0d cycles expected under %0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send_byte(input logic [7:0] d);
    bit ok;
    in_data = d; in_valid = 1;
    forever begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 0;
  endtask

  // Waits for the first driven cycle, then decodes 8 back-to-back bits.
  task automatic decode_byte(output logic [7:0] b);
    int guard = 0;
    while (!(tx_p || tx_n) && guard < 500) begin @(negedge clk); guard++; end
    for (int i = 0; i < 8; i++) begin
      bit h1n, h2p;
      h1n = tx_n;
      repeat (4) @(negedge clk);
      h2p = tx_p;
      chk("R1/R2", "second half mirrors first", h2p, h1n);
      b[i] = h1n;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] got;
    int k;
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    chk("R9", "tx_p after reset", tx_p, 0);
    chk("R9", "tx_n after reset", tx_n, 0);
    chk("R9", "done after reset", done, 0);
    chk("R9", "in_ready after reset", in_ready, 1);

    // R4 ordering plus R1/R2 shapes, then gap-free second byte
    fork
      begin send_byte(8'hA5); send_byte(8'h3C); end
      begin
        decode_byte(got);
        chk("R4", "first byte decoded", got, 8'hA5);
        decode_byte(got);
        chk("R4", "second byte back-to-back", got, 8'h3C);
      end
    join
    repeat (4) @(negedge clk);
    chk("R5", "lines rest low", tx_p | tx_n, 0);

    // R3 link pulse holds the start
    lp_busy = 1;
    send_byte(8'hFF);
    repeat (20) begin
      chk("R3", "held while busy", tx_p | tx_n, 0);
      @(negedge clk);
    end
    lp_busy = 0;
    decode_byte(got);
    chk("R3", "byte after release", got, 8'hFF);
    repeat (4) @(negedge clk);

    // R6/R7 frame end from idle, with a repeated request (R11)
    eof_delay = 16'd5; eof_req = 1;
    @(negedge clk);
    k = 1;
    chk("R8", "in_ready low during frame end", in_ready, 0);
    while (!tx_p && k < 100) begin @(negedge clk); k++; end
    eof_req = 0;
    chk("R6", "pulse start offset", k, 5 + 3);
    k = 0;
    while (tx_p && !tx_n && k < 100) begin k++; @(negedge clk); end
    chk("R6", "pulse width", k, 24);
    eof_req = 1; eof_delay = 16'd2;
    k = 0;
    while (k < 2000) begin
      k++;
      if (tx_p || tx_n) break;
      if (done) break;
      @(negedge clk);
    end
    eof_req = 0;
    chk("R7", "gap length to done", k, 512);
    chk("R11", "lines quiet in gap", tx_p | tx_n, 0);
    @(negedge clk);
    chk("R7", "done lasts one cycle", done, 0);
    repeat (40) begin
      chk("R11", "no second pulse", tx_p, 0);
      @(negedge clk);
    end

    // Frame end while bytes still queued
    send_byte(8'h81);
    eof_delay = 16'd90; eof_req = 1;
    @(negedge clk);
    eof_req = 0;
    repeat (700) @(negedge clk);

    // Random traffic, link pulses and frame ends against the model
    for (int c = 0; c < 6000; c++) begin
      lp_busy  = ($urandom_range(0, 11) == 0);
      in_valid = ($urandom_range(0, 2) != 0);
      in_data  = 8'($urandom);
      eof_req  = ($urandom_range(0, 400) == 0);
      eof_delay = 16'($urandom_range(0, 120));
      @(negedge clk);
    end
    in_valid = 0; eof_req = 0; lp_busy = 0;
    repeat (800) @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule